// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sleep and Wake Control

This block receives asynchronous serial characters on a single line. A baud strobe runs at sixteen times the bit rate. The block finds each start bit and recovers every bit by a three-sample majority vote taken around the bit centre. It assembles the character in a shift register. When the stop bit has been sampled, the character moves into a separate holding register, so the next character can shift in while software still has the previous one. Five status flags report the character: data ready, line idle, overrun, noise and bad stop bit. A single read strobe clears all five.

In a multi-drop network, a receiver that is not addressed by the current message can put itself to sleep. While it sleeps, it loads no characters and raises no status flag. Hardware wakes the receiver by one of two methods, chosen by a mode input. The first method wakes it when the line has stayed high for a whole frame time. The second wakes it on a character whose top data bit is 1, and that character is delivered like a normal one. The character length is 8 or 9 data bits, and the top data bit serves as the address mark.

Top module: `serial_rx_wake`

## Requirements
- R1: After reset, every status flag is 0, `sleeping` is 0 and `rx_data` is 0.
- R2: A frame is a 0 start bit, then 8 data bits (`nine_bit`=0) or 9 data bits (`nine_bit`=1) least significant bit first, then a stop bit. Bit timing counts `baud_tick` strobes, 16 per bit. The tick that first sees the line low is sample 0, and each bit is decided from its samples 7, 8 and 9. In 8-bit mode `rx_data[8]` is 0.
- R3: A completed character is copied to `rx_data` and sets `flag_full`. A one-cycle `rd_strobe` clears `flag_full`, `flag_idle`, `flag_ovr`, `flag_noise` and `flag_frame`.
- R4: A character that completes while `flag_full` is 1 sets `flag_ovr` and is discarded, so `rx_data` keeps the older character.
- R5: If the three samples of any bit (start, data or stop) do not all agree, `flag_noise` is set together with `flag_full`. The bit value is the majority of the samples.
- R6: A stop bit that votes 0 sets `flag_frame`, and the character is still loaded into `rx_data`.
- R7: A low pulse whose centre samples vote 1 is a false start. It produces no character and no flag.
- R8: `flag_idle` is set when the line has been high for 160 ticks (8-bit mode) or 176 ticks (9-bit mode), provided a character has been accepted since the previous idle detection. A low glitch that yields no character does not rearm it.
- R9: A `sleep_wr` pulse loads `sleep_val` into `sleeping`. This write takes priority over a hardware wake in the same cycle.
- R10: While `sleeping` is 1, characters are not loaded and no status flag can become set, except for the waking character of R12.
- R11: With `wake_sel`=0, the idle-line time of R8 clears `sleeping` without setting `flag_idle`, and the next character is received normally.
- R12: With `wake_sel`=1, a character whose top data bit (bit 7, or bit 8 in 9-bit mode) is 1 clears `sleeping`, is loaded and sets `flag_full`. Characters with that bit 0 are ignored, and an idle line does not wake the receiver.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, high when idle |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_sel | input | 1 | 0 selects idle-line wake, 1 selects address-mark wake |
| sleep_wr | input | 1 | Write strobe for the sleep control bit |
| sleep_val | input | 1 | Value written to the sleep control bit |
| rd_strobe | input | 1 | Data read strobe that clears all status flags |
| rx_data | output | 9 | Holding register for the last accepted character |
| flag_full | output | 1 | A character is waiting in `rx_data` |
| flag_idle | output | 1 | The line went idle after a received character |
| flag_ovr | output | 1 | A character was lost because `rx_data` was full |
| flag_noise | output | 1 | Disagreeing samples were seen in the loaded character |
| flag_frame | output | 1 | The loaded character had a 0 stop bit |
| sleeping | output | 1 | The receiver is in sleep mode |

## Verification
The hardest case to reach is the sleep window itself. The bench has to send a message while the receiver sleeps and confirm that nothing reaches the flags, including a noisy character and a character with a bad stop bit. It then has to show that the following idle gap, or the address-marked character, is what wakes the receiver. The stimulus sets the sleep bit only after the line has already been idle long enough for the idle detector to fire. It then sends back-to-back frames with no gap, so the only idle period that can wake the receiver is the one after the message. Noise comes from a four-cycle inversion near the bit centre. At one tick every four cycles, that inversion corrupts exactly one of the three voted samples.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    BK_START,
    BK_DATA,
    BK_STOP
  } bit_kind_e;

  typedef struct packed {
    logic val;
    logic noisy;
  } vote_t;

  function automatic vote_t vote3(input logic a, input logic b, input logic c);
    vote_t v;
    v.val   = (a & b) | (a & c) | (b & c);
    v.noisy = !((a == b) && (b == c));
    return v;
  endfunction

endpackage

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
  import serial_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DATA_MAX = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick,
  input  logic                        rxd,
  input  logic                        nine_bit,
  output logic                        line_s,
  output logic                        bit_stb,
  output bit_kind_e                   bit_kind,
  output logic                        bit_val,
  output logic                        bit_noisy,
  output logic [$clog2(DATA_MAX)-1:0] bit_idx
);
  localparam int PH_W  = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_MAX);
  localparam int MID   = OSR / 2;

  logic [1:0]       sync_q;
  rx_state_e        state;
  logic [PH_W-1:0]  ph;
  logic             s_a, s_b;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;
  vote_t            vote_now;

  assign line_s   = sync_q[1];
  assign last_idx = nine_bit ? IDX_W'(DATA_MAX - 1) : IDX_W'(DATA_MAX - 2);

  always_comb vote_now = vote3(s_a, s_b, line_s);

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ph        <= '0;
      s_a       <= 1'b1;
      s_b       <= 1'b1;
      idx       <= '0;
      bit_stb   <= 1'b0;
      bit_kind  <= BK_START;
      bit_val   <= 1'b1;
      bit_noisy <= 1'b0;
      bit_idx   <= '0;
    end else begin
      bit_stb <= 1'b0;
      if (tick) begin
        if (state == ST_IDLE) begin
          if (!line_s) begin
            state <= ST_START;
            ph    <= PH_W'(1);
          end
        end else begin
          ph <= (ph == PH_W'(OSR - 1)) ? '0 : ph + 1'b1;
          if (ph == PH_W'(MID - 1)) s_a <= line_s;
          if (ph == PH_W'(MID))     s_b <= line_s;
          if (ph == PH_W'(MID + 1)) begin
            case (state)
              ST_START: begin
                if (vote_now.val) begin
                  state <= ST_IDLE;
                end else begin
                  state     <= ST_DATA;
                  idx       <= '0;
                  bit_stb   <= 1'b1;
                  bit_kind  <= BK_START;
                  bit_val   <= 1'b0;
                  bit_noisy <= vote_now.noisy;
                end
              end
              ST_DATA: begin
                bit_stb   <= 1'b1;
                bit_kind  <= BK_DATA;
                bit_val   <= vote_now.val;
                bit_noisy <= vote_now.noisy;
                bit_idx   <= idx;
                if (idx == last_idx) state <= ST_STOP;
                else                 idx   <= idx + 1'b1;
              end
              default: begin
                bit_stb   <= 1'b1;
                bit_kind  <= BK_STOP;
                bit_val   <= vote_now.val;
                bit_noisy <= vote_now.noisy;
                state     <= ST_IDLE;
              end
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/rx_frame_shift.sv
module rx_frame_shift
  import serial_rx_pkg::*;
#(
  parameter int DATA_MAX = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bit_stb,
  input  bit_kind_e                   bit_kind,
  input  logic                        bit_val,
  input  logic                        bit_noisy,
  input  logic [$clog2(DATA_MAX)-1:0] bit_idx,
  output logic                        frm_done,
  output logic [DATA_MAX-1:0]         frm_char,
  output logic                        frm_noisy,
  output logic                        frm_bad_stop
);
  localparam int IDX_W = $clog2(DATA_MAX);

  logic [DATA_MAX-1:0] shreg;
  logic                noise_acc;

  genvar g;
  generate
    for (g = 0; g < DATA_MAX; g++) begin : g_cell
      always_ff @(posedge clk) begin
        if (rst) begin
          shreg[g] <= 1'b0;
        end else if (bit_stb) begin
          if (bit_kind == BK_START)
            shreg[g] <= 1'b0;
          else if (bit_kind == BK_DATA && bit_idx == IDX_W'(g))
            shreg[g] <= bit_val;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      noise_acc    <= 1'b0;
      frm_done     <= 1'b0;
      frm_char     <= '0;
      frm_noisy    <= 1'b0;
      frm_bad_stop <= 1'b0;
    end else begin
      frm_done <= 1'b0;
      if (bit_stb) begin
        case (bit_kind)
          BK_START: noise_acc <= bit_noisy;
          BK_DATA:  noise_acc <= noise_acc | bit_noisy;
          default: begin
            frm_done     <= 1'b1;
            frm_char     <= shreg;
            frm_noisy    <= noise_acc | bit_noisy;
            frm_bad_stop <= !bit_val;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int OSR      = 16,
  parameter int DATA_MAX = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line_s,
  input  logic nine_bit,
  output logic idle_evt
);
  localparam int LIM_MAX = (DATA_MAX + 2) * OSR;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = nine_bit ? CNT_W'(LIM_MAX) : CNT_W'(LIM_MAX - OSR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      idle_evt <= 1'b0;
    end else begin
      idle_evt <= 1'b0;
      if (tick) begin
        if (!line_s) begin
          cnt <= '0;
        end else if (cnt < limit) begin
          cnt <= cnt + 1'b1;
          if (cnt == limit - 1'b1) idle_evt <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rx_wake_status.sv
module rx_wake_status #(
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frm_done,
  input  logic [DATA_MAX-1:0] frm_char,
  input  logic                frm_noisy,
  input  logic                frm_bad_stop,
  input  logic                idle_evt,
  input  logic                sleep_wr,
  input  logic                sleep_val,
  input  logic                wake_sel,
  input  logic                nine_bit,
  input  logic                rd_strobe,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                flag_full,
  output logic                flag_idle,
  output logic                flag_ovr,
  output logic                flag_noise,
  output logic                flag_frame,
  output logic                sleeping
);
  logic mark_bit, addr_wake, line_wake, accept, idle_hit, armed;

  always_comb begin
    mark_bit  = nine_bit ? frm_char[DATA_MAX-1] : frm_char[DATA_MAX-2];
    addr_wake = sleeping && wake_sel && frm_done && mark_bit;
    line_wake = sleeping && !wake_sel && idle_evt;
    accept    = frm_done && (!sleeping || addr_wake);
    idle_hit  = idle_evt && armed && !sleeping;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data    <= '0;
      flag_full  <= 1'b0;
      flag_idle  <= 1'b0;
      flag_ovr   <= 1'b0;
      flag_noise <= 1'b0;
      flag_frame <= 1'b0;
      sleeping   <= 1'b0;
      armed      <= 1'b0;
    end else begin
      if (rd_strobe) begin
        flag_full  <= 1'b0;
        flag_idle  <= 1'b0;
        flag_ovr   <= 1'b0;
        flag_noise <= 1'b0;
        flag_frame <= 1'b0;
      end
      if (idle_evt) armed <= 1'b0;
      if (accept) begin
        armed <= 1'b1;
        if (flag_full) begin
          flag_ovr <= 1'b1;
        end else begin
          rx_data    <= frm_char;
          flag_full  <= 1'b1;
          flag_noise <= frm_noisy;
          flag_frame <= frm_bad_stop;
        end
      end
      if (idle_hit) flag_idle <= 1'b1;
      if (addr_wake || line_wake) sleeping <= 1'b0;
      if (sleep_wr) sleeping <= sleep_val;
    end
  end

endmodule

// File: rtl/serial_rx_wake.sv
module serial_rx_wake
  import serial_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rxd,
  input  logic                baud_tick,
  input  logic                nine_bit,
  input  logic                wake_sel,
  input  logic                sleep_wr,
  input  logic                sleep_val,
  input  logic                rd_strobe,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                flag_full,
  output logic                flag_idle,
  output logic                flag_ovr,
  output logic                flag_noise,
  output logic                flag_frame,
  output logic                sleeping
);
  localparam int IDX_W = $clog2(DATA_MAX);

  logic                line_s;
  logic                bit_stb, bit_val, bit_noisy;
  bit_kind_e           bit_kind;
  logic [IDX_W-1:0]    bit_idx;
  logic                frm_done, frm_noisy, frm_bad_stop;
  logic [DATA_MAX-1:0] frm_char;
  logic                idle_evt;

  rx_bit_sampler #(.OSR(OSR), .DATA_MAX(DATA_MAX)) u_smp (
    .clk       (clk),
    .rst       (rst),
    .tick      (baud_tick),
    .rxd       (rxd),
    .nine_bit  (nine_bit),
    .line_s    (line_s),
    .bit_stb   (bit_stb),
    .bit_kind  (bit_kind),
    .bit_val   (bit_val),
    .bit_noisy (bit_noisy),
    .bit_idx   (bit_idx)
  );

  rx_frame_shift #(.DATA_MAX(DATA_MAX)) u_frm (
    .clk          (clk),
    .rst          (rst),
    .bit_stb      (bit_stb),
    .bit_kind     (bit_kind),
    .bit_val      (bit_val),
    .bit_noisy    (bit_noisy),
    .bit_idx      (bit_idx),
    .frm_done     (frm_done),
    .frm_char     (frm_char),
    .frm_noisy    (frm_noisy),
    .frm_bad_stop (frm_bad_stop)
  );

  rx_idle_timer #(.OSR(OSR), .DATA_MAX(DATA_MAX)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .tick     (baud_tick),
    .line_s   (line_s),
    .nine_bit (nine_bit),
    .idle_evt (idle_evt)
  );

  rx_wake_status #(.DATA_MAX(DATA_MAX)) u_stat (
    .clk          (clk),
    .rst          (rst),
    .frm_done     (frm_done),
    .frm_char     (frm_char),
    .frm_noisy    (frm_noisy),
    .frm_bad_stop (frm_bad_stop),
    .idle_evt     (idle_evt),
    .sleep_wr     (sleep_wr),
    .sleep_val    (sleep_val),
    .wake_sel     (wake_sel),
    .nine_bit     (nine_bit),
    .rd_strobe    (rd_strobe),
    .rx_data      (rx_data),
    .flag_full    (flag_full),
    .flag_idle    (flag_idle),
    .flag_ovr     (flag_ovr),
    .flag_noise   (flag_noise),
    .flag_frame   (flag_frame),
    .sleeping     (sleeping)
  );

endmodule

// File: rtl/rx_wake_chk.sv
module rx_wake_chk (
  input logic clk,
  input logic rst,
  input logic rd_strobe,
  input logic sleep_wr,
  input logic wake_sel,
  input logic frm_done,
  input logic idle_evt,
  input logic flag_full,
  input logic flag_idle,
  input logic flag_ovr,
  input logic flag_noise,
  input logic flag_frame,
  input logic sleeping
);

  // R10
  sleep_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sleeping) && sleeping && !$past(sleep_wr)) |-> !$rose(flag_full));

  // R10
  sleep_err_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sleeping) && sleeping && !$past(sleep_wr)) |->
      (!$rose(flag_ovr) && !$rose(flag_noise) && !$rose(flag_frame) && !$rose(flag_idle)));

  // R4
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_ovr) |-> $past(flag_full));

  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !frm_done && !idle_evt) |=>
      (!flag_full && !flag_ovr && !flag_noise && !flag_frame && !flag_idle));

  // R12
  addr_wake_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sleeping) && !$past(sleep_wr) && $past(wake_sel)) |-> flag_full);

  // R11
  line_wake_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sleeping) && !$past(sleep_wr) && !$past(wake_sel)) |-> !$rose(flag_idle));

endmodule

bind serial_rx_wake rx_wake_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_strobe  (rd_strobe),
  .sleep_wr   (sleep_wr),
  .wake_sel   (wake_sel),
  .frm_done   (frm_done),
  .idle_evt   (idle_evt),
  .flag_full  (flag_full),
  .flag_idle  (flag_idle),
  .flag_ovr   (flag_ovr),
  .flag_noise (flag_noise),
  .flag_frame (flag_frame),
  .sleeping   (sleeping)
);

// File: tb/tb_serial_rx_wake.sv
module tb_serial_rx_wake;
  localparam int BIT = 64;  // 16 ticks of 4 clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       baud_tick = 1'b0;
  logic       nine_bit = 1'b0;
  logic       wake_sel = 1'b0;
  logic       sleep_wr = 1'b0;
  logic       sleep_val = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [8:0] rx_data;
  logic       flag_full, flag_idle, flag_ovr, flag_noise, flag_frame, sleeping;

  int n_chk  = 0;
  int n_fail = 0;

  serial_rx_wake dut (
    .clk(clk), .rst(rst), .rxd(rxd), .baud_tick(baud_tick),
    .nine_bit(nine_bit), .wake_sel(wake_sel), .sleep_wr(sleep_wr),
    .sleep_val(sleep_val), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .flag_full(flag_full), .flag_idle(flag_idle), .flag_ovr(flag_ovr),
    .flag_noise(flag_noise), .flag_frame(flag_frame), .sleeping(sleeping)
  );

  initial forever #4 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic stop_v, input int gl);
    rxd = 1'b0;
    hold(BIT);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      if (i == gl) begin
        hold(34); rxd = ~d[i]; hold(4); rxd = d[i]; hold(BIT - 38);
      end else begin
        hold(BIT);
      end
    end
    rxd = stop_v;
    hold(BIT);
    rxd = 1'b1;
    if (!stop_v) hold(BIT);
  endtask

  task automatic rd();
    rd_strobe = 1'b1; hold(1); rd_strobe = 1'b0; hold(1);
  endtask

  task automatic wr_sleep(input logic v);
    sleep_val = v; sleep_wr = 1'b1; hold(1); sleep_wr = 1'b0; hold(1);
  endtask

  task automatic settle();
    hold(12 * BIT);
    rd();
  endtask

  task automatic t_reset();
    chk("R1", "full", flag_full, 0);
    chk("R1", "idle", flag_idle, 0);
    chk("R1", "ovr/noise/frame", {flag_ovr, flag_noise, flag_frame}, 0);
    chk("R1", "sleeping", sleeping, 0);
    chk("R1", "data", rx_data, 0);
  endtask

  task automatic t_basic();
    settle();
    send(9'h0A5, 8, 1'b1, -1);
    chk("R2", "data A5", rx_data, 'hA5);
    chk("R3", "full set", flag_full, 1);
    chk("R3", "noise/frame clear", {flag_noise, flag_frame}, 0);
    rd();
    chk("R3", "full cleared by read", flag_full, 0);
    send(9'h03C, 8, 1'b1, -1);
    chk("R2", "data 3C", rx_data, 'h3C);
  endtask

  task automatic t_overrun();
    settle();
    send(9'h011, 8, 1'b1, -1);
    send(9'h022, 8, 1'b1, -1);
    chk("R4", "ovr set", flag_ovr, 1);
    chk("R4", "old data kept", rx_data, 'h11);
    rd();
    chk("R3", "ovr cleared", flag_ovr, 0);
  endtask

  task automatic t_noise();
    settle();
    send(9'h05A, 8, 1'b1, 3);
    chk("R5", "noise set", flag_noise, 1);
    chk("R5", "majority value", rx_data, 'h5A);
  endtask

  task automatic t_framing();
    settle();
    send(9'h033, 8, 1'b0, -1);
    chk("R6", "frame set", flag_frame, 1);
    chk("R6", "data loaded", rx_data, 'h33);
  endtask

  task automatic t_false_start();
    settle();
    rxd = 1'b0; hold(16); rxd = 1'b1; hold(3 * BIT);
    chk("R7", "no char", flag_full, 0);
    send(9'h044, 8, 1'b1, -1);
    chk("R7", "next char ok", rx_data, 'h44);
  endtask

  task automatic t_idle();
    settle();
    send(9'h077, 8, 1'b1, -1);
    chk("R8", "idle not yet", flag_idle, 0);
    hold(12 * BIT);
    chk("R8", "idle set", flag_idle, 1);
    rd();
    rxd = 1'b0; hold(16); rxd = 1'b1; hold(12 * BIT);
    chk("R8", "not rearmed", flag_idle, 0);
  endtask

  task automatic t_nine();
    nine_bit = 1'b1;
    settle();
    send(9'h1A5, 9, 1'b1, -1);
    chk("R2", "9-bit data", rx_data, 'h1A5);
    settle();
    nine_bit = 1'b0;
  endtask

  task automatic t_sleep_sw();
    wr_sleep(1'b1);
    chk("R9", "sleep set", sleeping, 1);
    wr_sleep(1'b0);
    chk("R9", "sleep cleared", sleeping, 0);
  endtask

  task automatic t_line_wake();
    wake_sel = 1'b0;
    settle();
    wr_sleep(1'b1);
    send(9'h081, 8, 1'b1, -1);
    send(9'h05A, 8, 1'b1, 3);
    send(9'h022, 8, 1'b0, -1);
    send(9'h023, 8, 1'b1, -1);
    chk("R10", "no load asleep", flag_full, 0);
    chk("R10", "no flags asleep", {flag_ovr, flag_noise, flag_frame, flag_idle}, 0);
    chk("R10", "still asleep", sleeping, 1);
    hold(12 * BIT);
    chk("R11", "woken by idle", sleeping, 0);
    chk("R11", "idle flag not set", flag_idle, 0);
    send(9'h066, 8, 1'b1, -1);
    chk("R11", "next char loaded", rx_data, 'h66);
    chk("R11", "full set", flag_full, 1);
  endtask

  task automatic t_addr_wake();
    wake_sel = 1'b1;
    settle();
    wr_sleep(1'b1);
    send(9'h012, 8, 1'b1, -1);
    chk("R12", "mark 0 ignored", {sleeping, flag_full}, 2'b10);
    hold(12 * BIT);
    chk("R12", "idle no wake", sleeping, 1);
    send(9'h085, 8, 1'b1, -1);
    chk("R12", "woken", sleeping, 0);
    chk("R12", "wake char loaded", rx_data, 'h85);
    chk("R12", "full set", flag_full, 1);
    nine_bit = 1'b1;
    settle();
    wr_sleep(1'b1);
    send(9'h0FF, 9, 1'b1, -1);
    chk("R12", "9-bit mark 0 ignored", {sleeping, flag_full}, 2'b10);
    send(9'h100, 9, 1'b1, -1);
    chk("R12", "9-bit woken", sleeping, 0);
    chk("R12", "9-bit wake char", rx_data, 'h100);
    nine_bit = 1'b0;
    wake_sel = 1'b0;
  endtask

  initial begin
    hold(5);
    rst = 1'b0;
    hold(2);
    t_reset();
    t_basic();
    t_overrun();
    t_noise();
    t_framing();
    t_false_start();
    t_idle();
    t_nine();
    t_sleep_sw();
    t_line_wake();
    t_addr_wake();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule